// File: doc/BRIEF.md
# Broadcast Poll Bit Responder

This block listens to the serial interrogation stream of a data-handling bus and answers the single-bit broadcast poll. While the sync strobe is high the block shifts in one serial bit per interrogation clock. When the strobe falls, it decodes the captured word. The word must be a full 32-bit word, carry the poll operation code and name this terminal's poll group. If all three hold, the block starts a timed response window. A single response bit then goes out on the response lines, in the bit period chosen by a 5-bit position input.

The response bit carries the level of the service-request input. Position 0 places the bit right after the fixed three-period response delay. Each step of the position adds one more bit period, up to position 23. Positions 24 to 31 keep the lines silent.

The position and service-request inputs are read on every clock of the window. Changing them during the window therefore produces more than one response bit. A common use is a set of three-period windows with a guard period on each side, which uses positions 1, 4, 7, 10, 13, 16, 19 and 22.

Top module: `poll_bit_responder`

## Requirements
- R1: While `irq_sync` is high, each rising clock edge shifts in `irq_sdata`. The first bit shifted is word bit 0. A word is decoded only when exactly 32 bits were shifted during that strobe; shorter and longer words are rejected.
- R2: A word is a broadcast poll only when bits 0, 1 and 2 hold 1, 0 and 1.
- R3: A poll is answered only when word bit 29 equals `grp_id[1]` and word bit 30 equals `grp_id[0]`.
- R4: Call E0 the first rising edge at which `irq_sync` is seen low after being high. With position P (0 to 23) present at edge E(3+P), `resp_en` is high for the one clock period following that edge.
- R5: During a response bit, `resp_data` equals the `svc_req` level sampled at the same edge that raised `resp_en`.
- R6: At any edge where `slot_pos` is 24 to 31, that edge raises no response, so no response bit appears in the following period.
- R7: `slot_pos` and `svc_req` are sampled at every edge of the window. A change during the window can yield several response bits, each following R4 and R5.
- R8: `resp_data` is low whenever `resp_en` is low.
- R9: A synchronous active-high `rst` clears the window and the capture state. `resp_en` and `resp_data` are low in the clock period after any reset edge.
- R10: Every falling edge of `irq_sync` ends a pending window. Only an accepted poll opens a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interrogation bit clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_sync | input | 1 | Interrogation sync strobe, high while a word is shifted |
| irq_sdata | input | 1 | Serial interrogation data |
| grp_id | input | 2 | Hard-wired poll group of this terminal |
| slot_pos | input | 5 | Response bit position, 0 to 23 active, 24 to 31 silent |
| svc_req | input | 1 | Service-request level returned in the response bit |
| resp_data | output | 1 | Response data line |
| resp_en | output | 1 | Response enable, high for each response bit period |

## Verification
The in-line assertions check the following on every clock:
- the data line stays quiet without the enable;
- an enable never follows a silent position;
- the data bit matches the service-request level of the edge before;
- the slot counter stays inside its window;
- a rejected word leaves no open window;
- reset silences the outputs.

The bench's scenarios cover what no single-cycle property can show. These are the exact response bit period for positions 0, 22 and 23; the rejection of short, long, foreign-group and wrong-operation words; and several response bits from mid-window position changes. They also cover a window cut short by a new strobe and by reset. A behavioural reference model is compared with the outputs in every cycle.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int BPR_WORD_W     = 32;
  localparam int BPR_POS_W      = 5;
  localparam int BPR_GID_W      = 2;
  localparam int BPR_GID_AT     = 29;
  localparam int BPR_OP_W       = 3;
  localparam int BPR_RESP_DELAY = 3;
  localparam int BPR_MAX_POS    = 23;

  // last edge index of the response window, counted from the decode edge
  function automatic int window_last(input int delay, input int max_pos);
    return delay + max_pos;
  endfunction

  // position value that is allowed to produce a response bit
  function automatic logic pos_active(input int pos, input int max_pos);
    return (pos <= max_pos);
  endfunction

  // edge index at which a given position raises the enable
  function automatic int slot_edge(input int pos, input int delay);
    return delay + pos;
  endfunction

  // true when the current edge index is the response edge for pos
  function automatic logic slot_hit(input int edge_idx, input int pos,
                                    input int delay, input int max_pos);
    return pos_active(pos, max_pos) && (edge_idx == slot_edge(pos, delay));
  endfunction

  // vector index of the word bit that arrived in position idx (first = 0)
  function automatic int arrival_index(input int idx, input int word_w);
    return word_w - 1 - idx;
  endfunction
endpackage

// File: rtl/bpr_word_capture.sv
module bpr_word_capture #(
  parameter int WORD_W = bpr_pkg::BPR_WORD_W,
  localparam int BCNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic [BCNT_W-1:0] bits_o,
  output logic              done_o
);
  localparam logic [BCNT_W-1:0] SAT = BCNT_W'(WORD_W + 1);

  logic              sync_q;
  logic [WORD_W-1:0] shreg;
  logic [BCNT_W-1:0] bcnt;
  logic              strobe_start;

  assign strobe_start = sync_i && !sync_q;
  assign done_o       = sync_q && !sync_i;
  assign word_o       = shreg;
  assign bits_o       = bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      bcnt   <= '0;
      shreg  <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_i) begin
        shreg <= {shreg[WORD_W-2:0], sdata_i};
        if (strobe_start)
          bcnt <= BCNT_W'(1);
        else if (bcnt != SAT)
          bcnt <= bcnt + 1'b1;
      end
    end
  end

  // the bit counter saturates one above a full word
  p_bitcnt_sat_r1: assert property (@(posedge clk) disable iff (rst)
    bits_o <= SAT);

  // a decode strobe only follows a cycle with the strobe high
  p_done_after_high_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(sync_i));

  // a fresh strobe restarts counting at one bit
  p_restart_count_r1: assert property (@(posedge clk) disable iff (rst)
    strobe_start |=> (bits_o == BCNT_W'(1)));
endmodule

// File: rtl/bpr_poll_decode.sv
module bpr_poll_decode #(
  parameter int WORD_W = bpr_pkg::BPR_WORD_W,
  parameter int GID_W  = bpr_pkg::BPR_GID_W,
  parameter int GID_AT = bpr_pkg::BPR_GID_AT,
  parameter int OP_W   = bpr_pkg::BPR_OP_W,
  parameter logic [OP_W-1:0] POLL_OP = 3'b101,
  localparam int BCNT_W = $clog2(WORD_W + 2)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [BCNT_W-1:0] bits_i,
  input  logic [GID_W-1:0]  gid_i,
  output logic              len_ok_o,
  output logic              op_ok_o,
  output logic              grp_ok_o,
  output logic              accept_o
);
  import bpr_pkg::*;

  localparam logic [BCNT_W-1:0] FULL = BCNT_W'(WORD_W);

  logic [OP_W-1:0]  op_eq;
  logic [GID_W-1:0] gid_eq;

  // operation code: first arrived bit compares with the code MSB
  for (genvar k = 0; k < OP_W; k++) begin : g_op
    assign op_eq[k] = (word_i[arrival_index(k, WORD_W)] == POLL_OP[OP_W-1-k]);
  end

  // group field: lower word index compares with the higher pin
  for (genvar j = 0; j < GID_W; j++) begin : g_gid
    assign gid_eq[j] = (word_i[arrival_index(GID_AT + j, WORD_W)] == gid_i[GID_W-1-j]);
  end

  assign len_ok_o = (bits_i == FULL);
  assign op_ok_o  = &op_eq;
  assign grp_ok_o = &gid_eq;
  assign accept_o = len_ok_o && op_ok_o && grp_ok_o;
endmodule

// File: rtl/bpr_slot_timer.sv
module bpr_slot_timer #(
  parameter int POS_W      = bpr_pkg::BPR_POS_W,
  parameter int RESP_DELAY = bpr_pkg::BPR_RESP_DELAY,
  parameter int MAX_POS    = bpr_pkg::BPR_MAX_POS,
  localparam int LAST      = bpr_pkg::window_last(RESP_DELAY, MAX_POS),
  localparam int CNT_W     = $clog2(LAST + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             accept_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             srq_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             data_o
);
  import bpr_pkg::*;

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             data_q;
  logic             hit;

  assign hit      = active && slot_hit(int'(cnt), int'(pos_i), RESP_DELAY, MAX_POS);
  assign active_o = active;
  assign cnt_o    = cnt;
  assign en_o     = en_q;
  assign data_o   = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      en_q   <= 1'b0;
      data_q <= 1'b0;
    end else if (start_i) begin
      active <= accept_i;
      cnt    <= CNT_W'(1);
      en_q   <= 1'b0;
      data_q <= 1'b0;
    end else if (active) begin
      en_q   <= hit;
      data_q <= hit && srq_i;
      cnt    <= cnt + 1'b1;
      if (cnt == LAST_C)
        active <= 1'b0;
    end else begin
      en_q   <= 1'b0;
      data_q <= 1'b0;
    end
  end

  p_quiet_data_r8: assert property (@(posedge clk) disable iff (rst)
    !en_o |-> !data_o);

  p_silent_pos_r6: assert property (@(posedge clk) disable iff (rst)
    en_o |-> (int'($past(pos_i)) <= MAX_POS));

  p_data_level_r5: assert property (@(posedge clk) disable iff (rst)
    en_o |-> (data_o == $past(srq_i)));

  p_cnt_window_r4: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (cnt_o >= CNT_W'(1) && cnt_o <= LAST_C));

  p_no_bit_on_decode_r10: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !en_o);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!en_o && !data_o && !active_o));
endmodule

// File: rtl/poll_bit_responder.sv
module poll_bit_responder #(
  parameter int WORD_W     = bpr_pkg::BPR_WORD_W,
  parameter int POS_W      = bpr_pkg::BPR_POS_W,
  parameter int GID_W      = bpr_pkg::BPR_GID_W,
  parameter int GID_AT     = bpr_pkg::BPR_GID_AT,
  parameter int RESP_DELAY = bpr_pkg::BPR_RESP_DELAY,
  parameter int MAX_POS    = bpr_pkg::BPR_MAX_POS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_sync,
  input  logic             irq_sdata,
  input  logic [GID_W-1:0] grp_id,
  input  logic [POS_W-1:0] slot_pos,
  input  logic             svc_req,
  output logic             resp_data,
  output logic             resp_en
);
  localparam int BCNT_W = $clog2(WORD_W + 2);
  localparam int LAST   = bpr_pkg::window_last(RESP_DELAY, MAX_POS);
  localparam int CNT_W  = $clog2(LAST + 2);

  logic [WORD_W-1:0] cap_word;
  logic [BCNT_W-1:0] cap_bits;
  logic              word_done;
  logic              len_ok;
  logic              op_ok;
  logic              grp_ok;
  logic              poll_accept;
  logic              win_active;
  logic [CNT_W-1:0]  win_cnt;

  bpr_word_capture #(.WORD_W(WORD_W)) i_capture (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (irq_sync),
    .sdata_i (irq_sdata),
    .word_o  (cap_word),
    .bits_o  (cap_bits),
    .done_o  (word_done)
  );

  bpr_poll_decode #(.WORD_W(WORD_W), .GID_W(GID_W), .GID_AT(GID_AT)) i_decode (
    .word_i   (cap_word),
    .bits_i   (cap_bits),
    .gid_i    (grp_id),
    .len_ok_o (len_ok),
    .op_ok_o  (op_ok),
    .grp_ok_o (grp_ok),
    .accept_o (poll_accept)
  );

  bpr_slot_timer #(.POS_W(POS_W), .RESP_DELAY(RESP_DELAY), .MAX_POS(MAX_POS)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (word_done),
    .accept_i (poll_accept),
    .pos_i    (slot_pos),
    .srq_i    (svc_req),
    .active_o (win_active),
    .cnt_o    (win_cnt),
    .en_o     (resp_en),
    .data_o   (resp_data)
  );

  // a decoded word in another group never opens a window
  p_foreign_group_r3: assert property (@(posedge clk) disable iff (rst)
    (word_done && !grp_ok) |=> !win_active);

  // a word with the wrong operation code never opens a window
  p_wrong_op_r2: assert property (@(posedge clk) disable iff (rst)
    (word_done && !op_ok) |=> !win_active);

  // a word of the wrong length never opens a window
  p_bad_length_r1: assert property (@(posedge clk) disable iff (rst)
    (word_done && !len_ok) |=> !win_active);

  // an accepted word opens the window at edge index one
  p_window_open_r10: assert property (@(posedge clk) disable iff (rst)
    (word_done && poll_accept) |=> (win_active && win_cnt == CNT_W'(1)));
endmodule

// File: tb/test_poll_bit_responder.sv
module test_poll_bit_responder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_sync = 1'b0;
  logic irq_sdata = 1'b0;
  logic [1:0] grp_id = 2'b10;
  logic [4:0] slot_pos = 5'd0;
  logic svc_req = 1'b0;
  logic resp_data;
  logic resp_en;

  always #5 clk = ~clk;

  poll_bit_responder i_poll_bit_responder (
    .clk(clk), .rst(rst), .irq_sync(irq_sync), .irq_sdata(irq_sdata),
    .grp_id(grp_id), .slot_pos(slot_pos), .svc_req(svc_req),
    .resp_data(resp_data), .resp_en(resp_en)
  );

  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  bit    checking = 0;
  bit    finished = 0;
  string tag = "R9 reset state";

  // behavioural reference model
  bit q_bits[$];
  bit m_syncq = 0;
  bit m_open  = 0;
  int m_edge  = 0;
  bit exp_en  = 0;
  bit exp_d   = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q_bits.delete();
      m_syncq = 0; m_open = 0; m_edge = 0; exp_en = 0; exp_d = 0;
    end else begin
      if (m_syncq && !irq_sync) begin
        m_open = (q_bits.size() == 32) && q_bits[0] && !q_bits[1] && q_bits[2]
                 && (q_bits[29] == grp_id[1]) && (q_bits[30] == grp_id[0]);
        m_edge = 1; exp_en = 0; exp_d = 0;
      end else if (m_open) begin
        exp_en = (slot_pos < 24) && (m_edge == 3 + slot_pos);
        exp_d  = exp_en && svc_req;
        if (m_edge == 26) m_open = 0;
        m_edge++;
      end else begin
        exp_en = 0; exp_d = 0;
      end
      if (irq_sync) begin
        if (!m_syncq) q_bits.delete();
        if (q_bits.size() < 33) q_bits.push_back(irq_sdata);
      end
      m_syncq = irq_sync;
    end
  end

  always @(negedge clk) begin
    if (checking && !finished) begin
      vectors++;
      if (resp_en !== exp_en || resp_data !== exp_d) begin
        fails++;
        $display("FAIL %s: en,data = %b,%b expected %b,%b", tag,
                 resp_en, resp_data, exp_en, exp_d);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [0:39] b, input int n);
    for (int i = 0; i < n; i++) begin
      irq_sync = 1'b1; irq_sdata = b[i];
      @(negedge clk);
    end
    irq_sync = 1'b0; irq_sdata = 1'b0;
  endtask

  function automatic logic [0:39] mk(input logic [2:0] op, input logic g29, input logic g30);
    logic [0:39] w = 40'h5AC396E12B;
    w[0:2] = op; w[29] = g29; w[30] = g30;
    return w;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    checking = 1;
    idle(2);
    rst = 1'b0;
    idle(2);

    tag = "R1 R2 R3 R4 R5 pos 0 bit set"; slot_pos = 0; svc_req = 1;
    send(mk(3'b101, 1, 0), 32); idle(30);
    tag = "R5 pos 22 bit clear"; slot_pos = 22; svc_req = 0;
    send(mk(3'b101, 1, 0), 32); idle(30);
    tag = "R4 pos 23 last slot"; slot_pos = 23; svc_req = 1;
    send(mk(3'b101, 1, 0), 32); idle(30);
    tag = "R6 pos 24 silent"; slot_pos = 24;
    send(mk(3'b101, 1, 0), 32); idle(30);
    tag = "R6 pos 31 silent"; slot_pos = 31;
    send(mk(3'b101, 1, 0), 32); idle(30);
    tag = "R3 group mismatch"; slot_pos = 4;
    send(mk(3'b101, 0, 0), 32); idle(30);
    tag = "R3 other group"; grp_id = 2'b01;
    send(mk(3'b101, 0, 1), 32); idle(30);
    tag = "R2 wrong operation"; grp_id = 2'b10;
    send(mk(3'b100, 1, 0), 32); idle(30);
    tag = "R1 short word"; send(mk(3'b101, 1, 0), 31); idle(30);
    tag = "R1 long word";  send(mk(3'b101, 1, 0), 33); idle(30);
    tag = "R8 R4 guard pos 7"; slot_pos = 7; svc_req = 1;
    send(mk(3'b101, 1, 0), 32); idle(30);

    tag = "R7 position change mid window"; slot_pos = 1; svc_req = 1;
    send(mk(3'b101, 1, 0), 32);
    idle(6); slot_pos = 7; svc_req = 0;
    idle(6); slot_pos = 13; svc_req = 1;
    idle(20);

    tag = "R10 window cut by new strobe"; slot_pos = 20; svc_req = 1;
    send(mk(3'b101, 1, 0), 32); idle(2);
    send(mk(3'b101, 1, 0), 5); idle(30);

    tag = "R9 reset during window"; slot_pos = 6; svc_req = 1;
    send(mk(3'b101, 1, 0), 32); idle(4);
    rst = 1'b1; idle(2); rst = 1'b0; idle(30);

    tag = "R4 R5 after reset"; slot_pos = 0; svc_req = 1;
    send(mk(3'b101, 1, 0), 32); idle(30);

    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, cycles %0d expected under %0d", cycles, 20000);
      finish_run();
    end
  end
endmodule